// File: doc/BRIEF.md
# Four-Stage Integer Pipeline with Token-Based Restart

This block is a small in-order 32-bit integer pipeline built from four stages in fixed order: Fetch, Decode with register read, Execute and Writeback. It understands four instructions only: register add, signed branch-if-less-than, word load and word store. Every other encoding passes through as a no-op. Program and data live in two small internal word arrays. A preload port writes them, normally while the core is held in reset. A debug port reads any architectural register combinationally.

A taken branch is handled without any per-stage valid flag. Execute is the only stage that may redirect the pipeline. It sends the new PC to Fetch and moves its two-state controller from a running state into a draining state. While draining, Execute still computes values but blocks every state-changing effect: register writeback, memory stores, operand forwarding of its result and further redirects. Fetch marks the first instruction fetched from the new PC with a token. When that token arrives in Execute, the controller returns to running, and the marked instruction takes full effect in that same cycle. A redirect costs two discarded instruction slots.

Operands are forwarded from Execute and from Writeback, so dependent instructions, including one that follows a load, run back to back without stalls.

Top module: `tokpipe_core`

## Requirements
- R1: While reset is asserted and after it, all registers read zero, the controller is in the running state, and the first instruction executed is the word at index 0 of program memory.
- R2: An instruction with major opcode 0110011, funct3 000 and funct7 0000000 writes rs1 + rs2 (modulo 2^32) into rd.
- R3: Load (opcode 0000011, funct3 010) and store (opcode 0100011, funct3 010) use the address rs1 plus the sign-extended 12-bit offset. Address bits [1:0] are ignored and bits above them select the data word. A load that follows a store to the same word returns the stored value.
- R4: A branch (opcode 1100011, funct3 100) is taken when rs1 < rs2 as signed 32-bit values. Its target is the branch PC plus the sign-extended B-type offset. A branch that is not taken does not disturb the sequential flow.
- R5: After a taken branch, the two instructions that follow it in memory change no register and no memory word, issue no redirect, and forward no value to later instructions.
- R6: The instruction at a branch target carries the restart token and executes fully, three cycles after the redirect. This holds even when that instruction is itself a taken branch.
- R7: An ADD whose source was written by one of the three preceding instructions reads the newest value, without a stall.
- R8: A load result is usable by the very next instruction, without a stall.
- R9: Register x0 always reads zero. Writes to it are discarded and are never forwarded.
- R10: Any encoding not listed in R2 to R4 leaves registers, memory and control flow unchanged.
- R11: The debug port returns the current contents of the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_we | input | 1 | Program memory preload write enable |
| imem_addr | input | IMEM_AW | Program memory word index for preload |
| imem_wdata | input | 32 | Program word to preload |
| dmem_we | input | 1 | Data memory preload write enable |
| dmem_addr | input | DMEM_AW | Data memory word index for preload |
| dmem_wdata | input | 32 | Data word to preload |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the register selected by dbg_addr |

## Verification
Two functions can fall in the same cycle. Operand forwarding can meet a flush when the branch target sits in Decode while a discarded producer of one of its source registers sits in Execute. The restart token can also arrive on an instruction that is itself a taken branch, so the controller leaves and re-enters the draining state together. The test programs place a discarded ADD to a register that the target reads, chain one taken branch directly onto another's target, and end in a branch to itself that redirects without end. The outcome is judged through the debug port: target results must show the committed value and never the discarded one, and registers written only in branch shadows must stay zero.

// File: rtl/tokpipe_pkg.sv
package tokpipe_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef enum logic [2:0] {OP_NOP, OP_ADD, OP_BLT, OP_LW, OP_SW} op_e;

  typedef struct packed {
    op_e             op;
    logic [RIDX-1:0] rs1;
    logic [RIDX-1:0] rs2;
    logic [RIDX-1:0] rd;
    logic [XLEN-1:0] imm;
  } dec_t;

  function automatic logic [XLEN-1:0] imm_i(input logic [31:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

  function automatic logic [XLEN-1:0] imm_s(input logic [31:0] w);
    return {{20{w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [XLEN-1:0] imm_b(input logic [31:0] w);
    return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic dec_t decode(input logic [31:0] w);
    dec_t d;
    d.rs1 = w[19:15];
    d.rs2 = w[24:20];
    d.rd  = w[11:7];
    d.op  = OP_NOP;
    d.imm = imm_i(w);
    case (w[6:0])
      7'b0110011: if (w[14:12] == 3'b000 && w[31:25] == 7'b0) d.op = OP_ADD;
      7'b1100011: if (w[14:12] == 3'b100) begin d.op = OP_BLT; d.imm = imm_b(w); end
      7'b0000011: if (w[14:12] == 3'b010) d.op = OP_LW;
      7'b0100011: if (w[14:12] == 3'b010) begin d.op = OP_SW; d.imm = imm_s(w); end
      default: d.op = OP_NOP;
    endcase
    return d;
  endfunction

  function automatic logic less_signed(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  // newest producer first: Execute, then Writeback, then the array
  function automatic logic [XLEN-1:0] pick_operand(
      input logic [RIDX-1:0] src,
      input logic x_we, input logic [RIDX-1:0] x_rd, input logic [XLEN-1:0] x_val,
      input logic w_we, input logic [RIDX-1:0] w_rd, input logic [XLEN-1:0] w_val,
      input logic [XLEN-1:0] arr_val);
    if (src == '0) return '0;
    if (x_we && x_rd == src) return x_val;
    if (w_we && w_rd == src) return w_val;
    return arr_val;
  endfunction
endpackage

// File: rtl/tp_fetch.sv
module tp_fetch
  import tokpipe_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               redirect_i,
  input  logic [XLEN-1:0]    target_i,
  input  logic               pre_we_i,
  input  logic [IMEM_AW-1:0] pre_addr_i,
  input  logic [31:0]        pre_data_i,
  output logic [31:0]        instr_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               tok_o
);
  localparam int DEPTH = 1 << IMEM_AW;

  logic [31:0]     prog [DEPTH];
  logic [XLEN-1:0] pc_q;
  logic            tok_q;
  logic [IMEM_AW-1:0] slot;

  assign slot = pc_q[IMEM_AW+1:2];

  always_ff @(posedge clk) begin
    if (pre_we_i) prog[pre_addr_i] <= pre_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      tok_q   <= 1'b0;
      pc_o    <= '0;
      tok_o   <= 1'b0;
      instr_o <= '0;
    end else begin
      instr_o <= prog[slot];
      pc_o    <= pc_q;
      tok_o   <= tok_q;
      pc_q    <= redirect_i ? target_i : pc_q + XLEN'(4);
      tok_q   <= redirect_i;
    end
  end

  // R6
  redirect_marks_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (tok_q && pc_q == $past(target_i)));

  // R1
  no_token_unasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_i |=> !tok_q);
endmodule

// File: rtl/tp_regfile.sv
module tp_regfile
  import tokpipe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w_we_i,
  input  logic [RIDX-1:0] w_rd_i,
  input  logic [XLEN-1:0] w_val_i,
  input  logic            x_we_i,
  input  logic [RIDX-1:0] x_rd_i,
  input  logic [XLEN-1:0] x_val_i,
  input  logic [RIDX-1:0] ra1_i,
  input  logic [RIDX-1:0] ra2_i,
  output logic [XLEN-1:0] rv1_o,
  output logic [XLEN-1:0] rv2_o,
  input  logic [RIDX-1:0] dbg_a_i,
  output logic [XLEN-1:0] dbg_d_o
);
  localparam int NREG = 1 << RIDX;

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (w_we_i && w_rd_i != '0) begin
      regs[w_rd_i] <= w_val_i;
    end
  end

  assign rv1_o   = pick_operand(ra1_i, x_we_i, x_rd_i, x_val_i, w_we_i, w_rd_i, w_val_i, regs[ra1_i]);
  assign rv2_o   = pick_operand(ra2_i, x_we_i, x_rd_i, x_val_i, w_we_i, w_rd_i, w_val_i, regs[ra2_i]);
  assign dbg_d_o = (dbg_a_i == '0) ? '0 : regs[dbg_a_i];

  // R9
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1_i == '0) |-> (rv1_o == '0));

  // R9
  zero_reg_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_we_i && w_rd_i == '0) |=> (regs[0] == '0));
endmodule

// File: rtl/tp_execute.sv
module tp_execute
  import tokpipe_pkg::*;
#(
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  op_e                op_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  input  logic [RIDX-1:0]    rd_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic               tok_i,
  input  logic               pre_we_i,
  input  logic [DMEM_AW-1:0] pre_addr_i,
  input  logic [XLEN-1:0]    pre_data_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    target_o,
  output logic               res_we_o,
  output logic [XLEN-1:0]    res_val_o,
  output logic               draining_o
);
  localparam int DEPTH = 1 << DMEM_AW;

  typedef enum logic {ST_RUN, ST_DRAIN} ctl_e;

  ctl_e               state_q;
  logic               live;
  logic               take;
  logic               store_go;
  logic [XLEN-1:0]    eff_addr;
  logic [DMEM_AW-1:0] word_idx;
  logic [XLEN-1:0]    load_val;
  logic [XLEN-1:0]    data [DEPTH];

  assign live       = (state_q == ST_RUN) || tok_i;
  assign draining_o = (state_q == ST_DRAIN);
  assign take       = (op_i == OP_BLT) && less_signed(a_i, b_i);
  assign redirect_o = live && take;
  assign target_o   = pc_i + imm_i;
  assign eff_addr   = a_i + imm_i;
  assign word_idx   = eff_addr[DMEM_AW+1:2];
  assign load_val   = data[word_idx];
  assign store_go   = live && (op_i == OP_SW);
  assign res_we_o   = live && (op_i == OP_ADD || op_i == OP_LW) && rd_i != '0;
  assign res_val_o  = (op_i == OP_LW) ? load_val : a_i + b_i;

  always_ff @(posedge clk) begin
    if (pre_we_i)      data[pre_addr_i] <= pre_data_i;
    else if (store_go) data[word_idx]   <= b_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= ST_RUN;
    else if (redirect_o) state_q <= ST_DRAIN;
    else if (tok_i)      state_q <= ST_RUN;
  end

  // R5
  enter_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (state_q == ST_DRAIN));

  // R6
  token_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_i && !redirect_o) |=> (state_q == ST_RUN));

  // R5
  drain_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && !tok_i) |=> (state_q == ST_DRAIN));

  // R4
  not_taken_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BLT && !less_signed(a_i, b_i)) |-> !redirect_o);
endmodule

// File: rtl/tokpipe_core.sv
module tokpipe_core
  import tokpipe_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_addr,
  input  logic [31:0]        imem_wdata,
  input  logic               dmem_we,
  input  logic [DMEM_AW-1:0] dmem_addr,
  input  logic [31:0]        dmem_wdata,
  input  logic [4:0]         dbg_addr,
  output logic [31:0]        dbg_data
);
  // Fetch -> Decode
  logic [31:0]     d_instr;
  logic [XLEN-1:0] d_pc;
  logic            d_tok;
  dec_t            d_dec;
  logic [XLEN-1:0] d_a, d_b;

  // Decode -> Execute
  op_e             x_op;
  logic [XLEN-1:0] x_pc, x_a, x_b, x_imm;
  logic [RIDX-1:0] x_rd;
  logic            x_tok;

  // Execute outputs
  logic            redirect;
  logic [XLEN-1:0] target;
  logic            x_we;
  logic [XLEN-1:0] x_val;
  logic            x_draining;

  // Execute -> Writeback
  logic            w_we;
  logic [RIDX-1:0] w_rd;
  logic [XLEN-1:0] w_val;

  tp_fetch #(.IMEM_AW(IMEM_AW)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .redirect_i(redirect), .target_i(target),
    .pre_we_i(imem_we), .pre_addr_i(imem_addr), .pre_data_i(imem_wdata),
    .instr_o(d_instr), .pc_o(d_pc), .tok_o(d_tok)
  );

  assign d_dec = decode(d_instr);

  tp_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .w_we_i(w_we), .w_rd_i(w_rd), .w_val_i(w_val),
    .x_we_i(x_we), .x_rd_i(x_rd), .x_val_i(x_val),
    .ra1_i(d_dec.rs1), .ra2_i(d_dec.rs2),
    .rv1_o(d_a), .rv2_o(d_b),
    .dbg_a_i(dbg_addr), .dbg_d_o(dbg_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_op  <= OP_NOP;
      x_pc  <= '0;
      x_a   <= '0;
      x_b   <= '0;
      x_rd  <= '0;
      x_imm <= '0;
      x_tok <= 1'b0;
    end else begin
      x_op  <= d_dec.op;
      x_pc  <= d_pc;
      x_a   <= d_a;
      x_b   <= d_b;
      x_rd  <= d_dec.rd;
      x_imm <= d_dec.imm;
      x_tok <= d_tok;
    end
  end

  tp_execute #(.DMEM_AW(DMEM_AW)) u_exe (
    .clk(clk), .rst_n(rst_n),
    .op_i(x_op), .pc_i(x_pc), .a_i(x_a), .b_i(x_b),
    .rd_i(x_rd), .imm_i(x_imm), .tok_i(x_tok),
    .pre_we_i(dmem_we), .pre_addr_i(dmem_addr), .pre_data_i(dmem_wdata),
    .redirect_o(redirect), .target_o(target),
    .res_we_o(x_we), .res_val_o(x_val), .draining_o(x_draining)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_we  <= 1'b0;
      w_rd  <= '0;
      w_val <= '0;
    end else begin
      w_we  <= x_we;
      w_rd  <= x_rd;
      w_val <= x_val;
    end
  end

  // R5
  shadow_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_draining && !x_tok) |=> !w_we);

  // R6
  token_round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ##3 x_tok);

  // R1
  first_fetch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (d_pc == '0 && !x_draining));
endmodule

// File: tb/sim_tokpipe_core.sv
`timescale 1ns/1ps
module sim_tokpipe_core;
  localparam int IAW = 6;
  localparam int DAW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           imem_we = 1'b0;
  logic [IAW-1:0] imem_addr = '0;
  logic [31:0]    imem_wdata = '0;
  logic           dmem_we = 1'b0;
  logic [DAW-1:0] dmem_addr = '0;
  logic [31:0]    dmem_wdata = '0;
  logic [4:0]     dbg_addr = '0;
  logic [31:0]    dbg_data;

  always #2.5 clk = ~clk;

  tokpipe_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          idx;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // instruction encoders
  function automatic logic [31:0] i_add(int rd, int rs1, int rs2);
    return {7'b0, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] i_lw(int rd, int rs1, int ofs);
    logic [11:0] o = 12'(ofs);
    return {o, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
  endfunction
  function automatic logic [31:0] i_sw(int rs2, int rs1, int ofs);
    logic [11:0] o = 12'(ofs);
    return {o[11:5], 5'(rs2), 5'(rs1), 3'b010, o[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] i_blt(int rs1, int rs2, int ofs);
    logic [12:0] o = 13'(ofs);
    return {o[12], o[10:5], 5'(rs2), 5'(rs1), 3'b100, o[4:1], o[11], 7'b1100011};
  endfunction

  // driver side: expected architectural results
  task automatic expect_reg(int idx, logic [31:0] val, string tag);
    exp_t e;
    e.idx = idx; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor side: pop and compare through the debug port
  task automatic monitor_drain();
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      @(negedge clk);
      dbg_addr = 5'(e.idx);
      #1;
      checks++;
      if (dbg_data !== e.val) begin
        failures++;
        $display("FAIL %s x%0d actual=%h expected=%h", e.tag, e.idx, dbg_data, e.val);
      end
    end
  endtask

  task automatic put_i(int idx, logic [31:0] w);
    @(negedge clk);
    imem_we = 1'b1; imem_addr = IAW'(idx); imem_wdata = w;
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic put_d(int idx, logic [31:0] w);
    @(negedge clk);
    dmem_we = 1'b1; dmem_addr = DAW'(idx); dmem_wdata = w;
    @(negedge clk);
    dmem_we = 1'b0;
  endtask

  task automatic prepare();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < (1 << IAW); i++) put_i(i, 32'h0);
    put_d(0, 32'd5);
    put_d(1, 32'd7);
    put_d(2, 32'hFFFF_FFFD);
    put_d(3, 32'd40);
    put_d(4, 32'd0);
  endtask

  task automatic run(int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // ---------------- program A: arithmetic, forwarding, memory
    prepare();
    // R1: registers read zero while held in reset
    expect_reg(1, 32'd0, "R1 reset x1");
    expect_reg(31, 32'd0, "R1 reset x31");
    monitor_drain();
    put_i(0, i_lw(1, 0, 0));          // x1 = 5 (first word executes: R1)
    put_i(1, i_lw(2, 0, 4));          // x2 = 7
    put_i(2, i_add(3, 1, 2));         // 12, load forwarded
    put_i(3, i_add(4, 3, 3));         // 24
    put_i(4, i_add(5, 3, 4));         // 36
    put_i(5, i_add(6, 3, 1));         // 17
    put_i(6, i_add(0, 1, 2));         // dropped
    put_i(7, i_add(7, 0, 1));         // 5
    put_i(8, i_sw(5, 0, 12));         // mem[3] = 36
    put_i(9, i_lw(8, 0, 12));         // 36
    put_i(10, i_add(9, 8, 8));        // 72
    put_i(11, 32'h0050_0093);         // unsupported: would set x1 = 5+... no effect
    put_i(12, 32'h0070_8093);         // unsupported: would set x1 = x1 + 7
    put_i(13, i_lw(10, 0, 9));        // low bits ignored -> word 2
    put_i(14, i_blt(0, 1, 0));        // park: branch to itself forever
    run(60);
    expect_reg(1, 32'd5, "R1 R10 first word executed, x1 untouched by unsupported codes");
    expect_reg(3, 32'd12, "R8 R2 load result forwarded to next add");
    expect_reg(4, 32'd24, "R7 distance-1 forward");
    expect_reg(5, 32'd36, "R7 distance-1 and distance-2 forward");
    expect_reg(6, 32'd17, "R7 distance-3 read");
    expect_reg(0, 32'd0, "R9 write to x0 discarded");
    expect_reg(7, 32'd5, "R9 x0 write not forwarded");
    expect_reg(8, 32'd36, "R3 load after store");
    expect_reg(9, 32'd72, "R8 load forwarded");
    expect_reg(10, 32'hFFFF_FFFD, "R3 address low bits ignored");
    expect_reg(2, 32'd7, "R11 debug read");
    monitor_drain();
    // R1: reset clears the register file
    @(negedge clk);
    rst_n = 1'b0;
    expect_reg(5, 32'd0, "R1 reset clears x5");
    expect_reg(9, 32'd0, "R1 reset clears x9");
    monitor_drain();

    // ---------------- program B: branches and the flush shadow
    prepare();
    put_i(0, i_lw(1, 0, 0));          // 5
    put_i(1, i_lw(2, 0, 4));          // 7
    put_i(2, i_lw(3, 0, 8));          // -3
    put_i(3, i_blt(1, 2, 12));        // taken -> 6
    put_i(4, i_sw(1, 0, 16));         // shadow
    put_i(5, i_add(10, 1, 1));        // shadow, same reg read by target
    put_i(6, i_add(4, 1, 10));        // target: 5 + 0
    put_i(7, i_blt(2, 1, 8));         // not taken
    put_i(8, i_add(5, 4, 4));         // 10
    put_i(9, i_blt(3, 1, 12));        // signed -3 < 5: taken -> 12
    put_i(10, i_add(6, 1, 1));        // shadow
    put_i(11, i_add(7, 1, 1));        // shadow
    put_i(12, i_blt(3, 1, 12));       // target that branches again -> 15
    put_i(13, i_add(8, 1, 1));        // shadow
    put_i(14, i_add(1, 2, 2));        // shadow, would clobber x1
    put_i(15, i_lw(11, 0, 16));       // 0: shadow store had no effect
    put_i(16, i_add(12, 10, 1));      // 5
    put_i(17, i_blt(0, 1, 0));        // park
    run(60);
    expect_reg(4, 32'd5, "R5 discarded producer not forwarded to target");
    expect_reg(10, 32'd0, "R5 shadow add did not write");
    expect_reg(11, 32'd0, "R5 shadow store did not write memory");
    expect_reg(5, 32'd10, "R4 not-taken branch falls through");
    expect_reg(6, 32'd0, "R4 signed compare taken, shadow x6 skipped");
    expect_reg(7, 32'd0, "R5 second shadow slot skipped");
    expect_reg(8, 32'd0, "R6 target branch redirects again, x8 skipped");
    expect_reg(1, 32'd5, "R5 shadow after chained redirect discarded");
    expect_reg(12, 32'd5, "R6 instruction after chained target executes");
    monitor_drain();

    // ---------------- program C: backward loop
    prepare();
    put_i(0, i_lw(1, 0, 0));          // 5
    put_i(1, i_lw(5, 0, 12));         // 40
    put_i(2, i_add(4, 4, 1));         // x4 += 5
    put_i(3, i_blt(4, 5, -4));        // loop while x4 < 40
    put_i(4, i_add(6, 4, 0));         // copy
    put_i(5, i_blt(0, 1, 0));         // park
    run(80);
    expect_reg(4, 32'd40, "R4 backward branch loop count");
    expect_reg(6, 32'd40, "R6 fall-through after loop exit");
    monitor_drain();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule